// File: doc/BRIEF.md
# Accumulator ALU with NZCV Flags

This block is the datapath core of a small accumulator-based processor. It keeps the accumulator, two index registers and a five-bit status word: carry, zero, overflow, negative and interrupt-disable. Each cycle with `en` high, the operation on `op` is applied to the registers and to the byte on `operand`. Every register and flag update lands on the rising clock edge. Instruction fetch, decoding and address generation stay outside the block, and the sequencer only presents an operation code and an operand byte.

Some operations modify a memory operand: increment, decrement, the shifts and rotates, and the fused read-modify-write forms. These return the new byte on `mem_out` and pulse `mem_wr` for one cycle, so the sequencer can write the byte back. A fused operation first modifies the operand and then feeds the modified byte into an accumulator operation in the same cycle. In the rotate-right form, the carry produced by the rotate is the carry-in of the addition that follows.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high `rst` clears `acc`, `xr`, `yr`, `mem_out`, `mem_wr` and all five flags on the next rising edge.
- R2: With `en` low, or with op 0 (no operation), the registers, `mem_out` and the flags keep their values, and `mem_wr` is 0 after the edge. Codes 30 and 31 behave as op 0.
- R3: Op 1 loads `operand` into A, op 2 loads it into X and op 3 loads it into Y. Op 25 loads it into both A and X. Loads set Z when the value is 0 and set N from bit 7 of the value. C, V and I keep their values.
- R4: Op 4 (add with carry) sets A to (A + operand + C) mod 256 and sets C to the unsigned carry out. V is set when A and the operand have the same sign and the result's sign differs. Z and N follow the result.
- R5: Op 5 (subtract with borrow) is op 4 applied to the bitwise inverse of the operand. When C is 0, one more unit is subtracted.
- R6: Ops 6 (AND), 7 (OR) and 8 (XOR) combine A with the operand and write the result to A. They update only Z and N.
- R7: Op 9 (bit test) sets Z when A AND operand is 0, copies operand bit 6 into V and copies operand bit 7 into N. A and C are unchanged.
- R8: Ops 10, 11 and 12 compare A, X and Y respectively (u) against the operand (v). C is set when u >= v (unsigned), Z is set when u == v, and N takes bit 7 of (u - v) mod 256. No register is written and V is unchanged.
- R9: Op 13 (increment) and op 14 (decrement) return (operand ± 1) mod 256 on `mem_out` with `mem_wr` = 1, and set Z and N from that result. Every operation that modifies the operand (ops 13 to 24) pulses `mem_wr`, and no other operation does.
- R10: Ops 15 to 18 return the modified operand on `mem_out`. Op 15 shifts left and moves old bit 7 into C. Op 16 shifts right logically and moves old bit 0 into C. Op 17 rotates left through C and op 18 rotates right through C, each taking C from the bit shifted out. Z and N follow the result.
- R11: The fused ops each return their modified operand on `mem_out`. Op 19 decrements, then compares A against the result. Op 20 increments, then subtracts the result from A with borrow. Op 21 rotates left, then ANDs the result into A. Op 22 rotates right, then adds the result to A using the carry produced by the rotate. Op 23 shifts left, then ORs the result into A. Op 24 shifts right, then XORs the result into A. After op 21, 23 or 24, C comes from the modify step and Z and N come from A.
- R12: Op 26 sets C, op 27 clears C, op 28 sets I and op 29 clears I. I changes under no other operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Applies `op` on this edge |
| op | input | 5 | Operation code (see requirements) |
| operand | input | W (8) | Memory or immediate operand byte |
| acc | output | W | Accumulator |
| xr | output | W | X index register |
| yr | output | W | Y index register |
| mem_out | output | W | Modified operand from the last modifying op |
| mem_wr | output | 1 | One-cycle strobe: `mem_out` is new |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_i | output | 1 | Interrupt-disable flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
A fused operation runs the operand modify unit and the accumulator adder, logic unit or comparator in the same cycle. The risky case is the rotate-right-then-add form, where the carry that leaves the rotate must be the carry that enters the adder, not the stored C. The bench provokes this with directed vectors in which the stored C differs from operand bit 0. It also runs a long random run of every operation against a behavioural model that applies the modify step and the accumulator step one after the other. On every clock it compares the registers, the flags and the memory write-back against that model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,
    OP_LDA  = 5'd1,
    OP_LDX  = 5'd2,
    OP_LDY  = 5'd3,
    OP_ADC  = 5'd4,
    OP_SBC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_BIT  = 5'd9,
    OP_CMPA = 5'd10,
    OP_CMPX = 5'd11,
    OP_CMPY = 5'd12,
    OP_INC  = 5'd13,
    OP_DEC  = 5'd14,
    OP_SHL  = 5'd15,
    OP_SHR  = 5'd16,
    OP_ROL  = 5'd17,
    OP_ROR  = 5'd18,
    OP_DECC = 5'd19,
    OP_INCS = 5'd20,
    OP_ROLA = 5'd21,
    OP_RORA = 5'd22,
    OP_SHLO = 5'd23,
    OP_SHRX = 5'd24,
    OP_LDAX = 5'd25,
    OP_SETC = 5'd26,
    OP_CLRC = 5'd27,
    OP_SETI = 5'd28,
    OP_CLRI = 5'd29
  } op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic i;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] full;

  assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];
  assign cout = full[W];
endmodule

// File: rtl/acc_alu_modify.sv
module acc_alu_modify
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] din,
  input  logic         cin,
  output logic [W-1:0] dout,
  output logic         cout,
  output logic         active
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    dout   = din;
    cout   = cin;
    active = 1'b1;
    unique case (op)
      OP_INC, OP_INCS: dout = din + ONE;
      OP_DEC, OP_DECC: dout = din - ONE;
      OP_SHL, OP_SHLO: begin
        dout = {din[W-2:0], 1'b0};
        cout = din[W-1];
      end
      OP_SHR, OP_SHRX: begin
        dout = {1'b0, din[W-1:1]};
        cout = din[0];
      end
      OP_ROL, OP_ROLA: begin
        dout = {din[W-2:0], cin};
        cout = din[W-1];
      end
      OP_ROR, OP_RORA: begin
        dout = {cin, din[W-1:1]};
        cout = din[0];
      end
      default: active = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    operand,
  output logic [W-1:0]    acc,
  output logic [W-1:0]    xr,
  output logic [W-1:0]    yr,
  output logic [W-1:0]    mem_out,
  output logic            mem_wr,
  output logic            flag_n,
  output logic            flag_v,
  output logic            flag_i,
  output logic            flag_z,
  output logic            flag_c
);
  localparam int MSB = W - 1;

  op_e          opc;
  logic [W-1:0] a_q, a_d, x_q, x_d, y_q, y_d, m_q, m_d;
  logic         wr_q, wr_d;
  flags_t       fl_q, fl_d;

  logic [W-1:0] mod_val;
  logic         mod_c, mod_act;
  logic [W-1:0] add_b, add_sum;
  logic         add_cin, add_c, add_ovf;
  logic [W-1:0] cmp_u, cmp_v, cmp_diff;
  logic         cmp_c;
  logic [W-1:0] lg_b, lg_res;

  assign opc = op_e'(op);

  acc_alu_modify #(.W(W)) u_modify (
    .op    (opc),
    .din   (operand),
    .cin   (fl_q.c),
    .dout  (mod_val),
    .cout  (mod_c),
    .active(mod_act)
  );

  always_comb begin
    unique case (opc)
      OP_SBC:  add_b = ~operand;
      OP_INCS: add_b = ~mod_val;
      OP_RORA: add_b = mod_val;
      default: add_b = operand;
    endcase
    add_cin = (opc == OP_RORA) ? mod_c : fl_q.c;
  end

  acc_alu_adder #(.W(W)) u_arith (
    .a   (a_q),
    .b   (add_b),
    .cin (add_cin),
    .sum (add_sum),
    .cout(add_c)
  );

  assign add_ovf = (a_q[MSB] == add_b[MSB]) && (add_sum[MSB] != a_q[MSB]);

  always_comb begin
    unique case (opc)
      OP_CMPX: cmp_u = x_q;
      OP_CMPY: cmp_u = y_q;
      default: cmp_u = a_q;
    endcase
    cmp_v = (opc == OP_DECC) ? mod_val : operand;
  end

  acc_alu_adder #(.W(W)) u_compare (
    .a   (cmp_u),
    .b   (~cmp_v),
    .cin (1'b1),
    .sum (cmp_diff),
    .cout(cmp_c)
  );

  always_comb begin
    lg_b = mod_act ? mod_val : operand;
    unique case (opc)
      OP_AND, OP_ROLA: lg_res = a_q & lg_b;
      OP_OR,  OP_SHLO: lg_res = a_q | lg_b;
      default:         lg_res = a_q ^ lg_b;
    endcase
  end

  always_comb begin
    a_d  = a_q;
    x_d  = x_q;
    y_d  = y_q;
    m_d  = m_q;
    fl_d = fl_q;
    wr_d = 1'b0;
    if (mod_act) begin
      m_d    = mod_val;
      wr_d   = 1'b1;
      fl_d.c = mod_c;
      fl_d.z = (mod_val == '0);
      fl_d.n = mod_val[MSB];
    end
    unique case (opc)
      OP_LDA, OP_LDX, OP_LDY, OP_LDAX: begin
        if (opc == OP_LDA || opc == OP_LDAX) a_d = operand;
        if (opc == OP_LDX || opc == OP_LDAX) x_d = operand;
        if (opc == OP_LDY) y_d = operand;
        fl_d.z = (operand == '0);
        fl_d.n = operand[MSB];
      end
      OP_ADC, OP_SBC, OP_INCS, OP_RORA: begin
        a_d    = add_sum;
        fl_d.c = add_c;
        fl_d.v = add_ovf;
        fl_d.z = (add_sum == '0);
        fl_d.n = add_sum[MSB];
      end
      OP_AND, OP_OR, OP_XOR, OP_ROLA, OP_SHLO, OP_SHRX: begin
        a_d    = lg_res;
        fl_d.z = (lg_res == '0);
        fl_d.n = lg_res[MSB];
      end
      OP_BIT: begin
        fl_d.z = ((a_q & operand) == '0);
        fl_d.v = operand[MSB-1];
        fl_d.n = operand[MSB];
      end
      OP_CMPA, OP_CMPX, OP_CMPY, OP_DECC: begin
        fl_d.c = cmp_c;
        fl_d.z = (cmp_u == cmp_v);
        fl_d.n = cmp_diff[MSB];
      end
      OP_SETC: fl_d.c = 1'b1;
      OP_CLRC: fl_d.c = 1'b0;
      OP_SETI: fl_d.i = 1'b1;
      OP_CLRI: fl_d.i = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      x_q  <= '0;
      y_q  <= '0;
      m_q  <= '0;
      wr_q <= 1'b0;
      fl_q <= '0;
    end else if (en) begin
      a_q  <= a_d;
      x_q  <= x_d;
      y_q  <= y_d;
      m_q  <= m_d;
      wr_q <= wr_d;
      fl_q <= fl_d;
    end else begin
      wr_q <= 1'b0;
    end
  end

  assign acc     = a_q;
  assign xr      = x_q;
  assign yr      = y_q;
  assign mem_out = m_q;
  assign mem_wr  = wr_q;
  assign flag_n  = fl_q.n;
  assign flag_v  = fl_q.v;
  assign flag_i  = fl_q.i;
  assign flag_z  = fl_q.z;
  assign flag_c  = fl_q.c;
endmodule

// File: rtl/acc_alu_checks.sv
module acc_alu_checks
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [OP_W-1:0] op,
  input logic [W-1:0]    operand,
  input logic [W-1:0]    acc,
  input logic [W-1:0]    xr,
  input logic [W-1:0]    yr,
  input logic            mem_wr,
  input logic            flag_n,
  input logic            flag_v,
  input logic            flag_i,
  input logic            flag_z,
  input logic            flag_c
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc == '0 && xr == '0 && yr == '0 && !mem_wr &&
             !flag_n && !flag_v && !flag_i && !flag_z && !flag_c));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(acc) && $stable(xr) && $stable(yr) && !mem_wr &&
             $stable({flag_n, flag_v, flag_i, flag_z, flag_c})));

  a_r3_load_acc: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_LDA) |=> (acc == $past(operand) && flag_z == (acc == '0) &&
                              flag_n == acc[W-1] && $stable(flag_c) && $stable(flag_v)));

  a_r7_bit_test: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_BIT) |=> (flag_v == $past(operand[W-2]) &&
                              flag_n == $past(operand[W-1]) &&
                              $stable(acc) && $stable(flag_c)));

  a_r8_compare_no_write: assert property (@(posedge clk) disable iff (rst)
    (en && (op == OP_CMPA || op == OP_CMPX || op == OP_CMPY)) |=>
      ($stable(acc) && $stable(xr) && $stable(yr) && $stable(flag_v) && !mem_wr));

  a_r9_modify_strobe: assert property (@(posedge clk) disable iff (rst)
    en |=> (mem_wr == ($past(op) >= OP_INC && $past(op) <= OP_SHRX)));

  a_r12_irq_flag_only: assert property (@(posedge clk) disable iff (rst)
    (en && op != OP_SETI && op != OP_CLRI) |=> $stable(flag_i));
endmodule

bind acc_alu acc_alu_checks #(.W(W)) u_checks (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .op     (op),
  .operand(operand),
  .acc    (acc),
  .xr     (xr),
  .yr     (yr),
  .mem_wr (mem_wr),
  .flag_n (flag_n),
  .flag_v (flag_v),
  .flag_i (flag_i),
  .flag_z (flag_z),
  .flag_c (flag_c)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] operand = '0;
  logic [7:0] acc, xr, yr, mem_out;
  logic       mem_wr, flag_n, flag_v, flag_i, flag_z, flag_c;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  int m_a, m_x, m_y, m_mem;
  bit m_wr, m_n, m_v, m_i, m_z, m_c;

  always #4 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst(rst), .en(en), .op(op), .operand(operand),
    .acc(acc), .xr(xr), .yr(yr), .mem_out(mem_out), .mem_wr(mem_wr),
    .flag_n(flag_n), .flag_v(flag_v), .flag_i(flag_i), .flag_z(flag_z), .flag_c(flag_c)
  );

  function automatic string tag_of(input bit e, input int o);
    if (!e || o == 0 || o >= 30) return "R2";
    if (o <= 3 || o == 25) return "R3";
    if (o == 4) return "R4";
    if (o == 5) return "R5";
    if (o <= 8) return "R6";
    if (o == 9) return "R7";
    if (o <= 12) return "R8";
    if (o <= 14) return "R9";
    if (o <= 18) return "R10";
    if (o <= 24) return "R11";
    return "R12";
  endfunction

  task automatic set_zn(input int r);
    m_z = (r == 0);
    m_n = (r >= 128);
  endtask

  task automatic do_add(input int b, input bit cin);
    int s;
    s = m_a + b + cin;
    m_v = (((m_a ^ s) & (b ^ s) & 128) != 0);
    m_c = (s > 255);
    m_a = s % 256;
    set_zn(m_a);
  endtask

  task automatic do_cmp(input int u, input int v);
    m_c = (u >= v);
    m_z = (u == v);
    m_n = (((u - v + 256) % 256) >= 128);
  endtask

  task automatic model(input bit e, input int o, input int v);
    int r;
    bit oc;
    m_wr = 0;
    if (!e) return;
    oc = m_c;
    case (o)
      1: begin m_a = v; set_zn(v); end
      2: begin m_x = v; set_zn(v); end
      3: begin m_y = v; set_zn(v); end
      25: begin m_a = v; m_x = v; set_zn(v); end
      4: do_add(v, m_c);
      5: do_add(255 - v, m_c);
      6: begin m_a = m_a & v; set_zn(m_a); end
      7: begin m_a = m_a | v; set_zn(m_a); end
      8: begin m_a = m_a ^ v; set_zn(m_a); end
      9: begin m_z = ((m_a & v) == 0); m_v = ((v & 64) != 0); m_n = (v >= 128); end
      10: do_cmp(m_a, v);
      11: do_cmp(m_x, v);
      12: do_cmp(m_y, v);
      26: m_c = 1;
      27: m_c = 0;
      28: m_i = 1;
      29: m_i = 0;
      default: ;
    endcase
    if (o >= 13 && o <= 24) begin
      case (o)
        13, 20: r = (v + 1) % 256;
        14, 19: r = (v + 255) % 256;
        15, 23: begin r = (v * 2) % 256; m_c = (v >= 128); end
        16, 24: begin r = v / 2; m_c = v % 2; end
        17, 21: begin r = (v * 2) % 256 + oc; m_c = (v >= 128); end
        default: begin r = v / 2 + oc * 128; m_c = v % 2; end
      endcase
      m_mem = r;
      m_wr = 1;
      set_zn(r);
      case (o)
        19: do_cmp(m_a, r);
        20: do_add(255 - r, m_c);
        21: begin m_a = m_a & r; set_zn(m_a); end
        22: do_add(r, m_c);
        23: begin m_a = m_a | r; set_zn(m_a); end
        24: begin m_a = m_a ^ r; set_zn(m_a); end
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag);
    logic [44:0] act, exp;
    act = {acc, xr, yr, mem_out, mem_wr, flag_n, flag_v, flag_i, flag_z, flag_c};
    exp = {m_a[7:0], m_x[7:0], m_y[7:0], m_mem[7:0], m_wr, m_n, m_v, m_i, m_z, m_c};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (a x y mem wr NVIZC)", tag, act, exp);
    end
  endtask

  task automatic step(input bit e, input int o, input int v);
    en = e;
    op = o[4:0];
    operand = v[7:0];
    model(e, o, v);
    @(negedge clk);
    check(tag_of(e, o));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_a = 0; m_x = 0; m_y = 0; m_mem = 0;
    m_wr = 0; m_n = 0; m_v = 0; m_i = 0; m_z = 0; m_c = 0;
    check("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R3 loads, zero and negative
    step(1, 1, 8'h00);
    step(1, 1, 8'h80);
    step(1, 2, 8'h7F);
    step(1, 3, 8'hC3);
    // R4 signed overflow, then unsigned carry
    step(1, 1, 8'h50);
    step(1, 4, 8'h50);
    step(1, 4, 8'h60);
    // R5 borrow with C = 0 and C = 1
    step(1, 27, 0);
    step(1, 5, 8'h10);
    step(1, 26, 0);
    step(1, 5, 8'hFF);
    // R6 logic ops
    step(1, 6, 8'h0F);
    step(1, 7, 8'h81);
    step(1, 8, 8'hFF);
    // R7 bit test
    step(1, 1, 8'h18);
    step(1, 9, 8'hE0);
    step(1, 9, 8'h3C);
    // R8 compares equal / greater / less
    step(1, 10, 8'h18);
    step(1, 11, 8'h10);
    step(1, 12, 8'hC4);
    // R9 increment/decrement wrap and Z on decrement of 1
    step(1, 13, 8'hFF);
    step(1, 14, 8'h01);
    step(1, 14, 8'h00);
    // R10 shifts and rotates through carry
    step(1, 15, 8'h98);
    step(1, 17, 8'h40);
    step(1, 18, 8'h01);
    step(1, 16, 8'h81);
    // R11 fused forms; RRA with stored C differing from operand bit 0
    step(1, 27, 0);
    step(1, 22, 8'h03);
    step(1, 26, 0);
    step(1, 22, 8'h02);
    step(1, 19, 8'h19);
    step(1, 20, 8'h0F);
    step(1, 21, 8'hC1);
    step(1, 23, 8'h41);
    step(1, 24, 8'h03);
    step(1, 25, 8'h9A);
    // R12 interrupt flag
    step(1, 28, 0);
    step(1, 4, 8'h01);
    step(1, 29, 0);
    // R2 idle and no-op
    step(0, 1, 8'h55);
    step(0, 13, 8'h55);
    step(1, 0, 8'h55);
    step(1, 31, 8'h55);
    // random run over all operations
    for (int k = 0; k < 1500; k++) begin
      step(($urandom % 8) != 0, $urandom % 32, $urandom % 256);
    end
    // R1 reset in mid-run
    step(1, 28, 0);
    step(1, 1, 8'hAA);
    do_reset();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule